// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This block is the guard that sits between the command decoder of a serial memory and its array sequencer. It holds the write enable latch and the protection configuration: a protection-enable flag and a two-bit block-protect field. From these it decides, one clock after each request, whether a data write, an erase or an update of the protection configuration may start. The serial shifter feeds it command strobes, the number of bits clocked in the current select frame, and a strobe for the end of each frame. The array sequencer feeds it the busy (write-in-progress) level. The block returns a status byte together with grant and deny pulses.

A write enable command does not act when it is decoded. It is held as pending and only sets the latch when the frame closes after exactly eight bits. A write sent in the same frame as the enable therefore still sees the latch clear. The protected region always covers the top of the array. It can cover nothing, the upper quarter, the upper half or the whole array, and each quarter is one sector. The latch clears by itself when a write cycle ends, when a disable command arrives, and when a request targets a protected location.

Top module: `wep_guard`

## Requirements
- R1: While reset is held, and at the first check after it, the status byte reads 00h and all four grant and deny pulses are low.
- R2: A write enable strobe sets the latch only at the next frame-end strobe whose bit count equals 8. A frame end with any other count drops the pending enable, and a frame end with nothing pending leaves the latch unchanged.
- R3: A write or erase request made after a write enable strobe but before its frame ends is denied, because the latch is still clear. The enable still takes effect at that frame's end.
- R4: A write disable strobe clears the latch at the next clock and cancels a pending write enable.
- R5: The status byte holds the protection-enable flag in bit 7, the block-protect field in bits 3:2, the latch in bit 1 and the registered busy level in bit 0. Bits 6:4 read 0. Each field reflects its state one clock after that state's input changes.
- R6: With ADDR_W address bits, block-protect 00 protects nothing. 01 protects addresses whose two top bits are 11 (18000h to 1FFFFh at 17 bits). 10 protects addresses whose top bit is 1. 11 protects every address. A whole-array erase request (chip flag high) counts as protected unless the field is 00.
- R7: A request is granted (req_grant_o high for one cycle, on the clock after the request) only when the latch is set, the target is unprotected and the array is not busy. Otherwise req_deny_o pulses in that cycle instead. The two never pulse together.
- R8: A request denied because its target is protected also clears the latch. A request denied only because the latch is clear leaves it clear and keeps any pending enable.
- R9: A configuration write is refused when the protection-enable flag is 1 and wp_n_i is low, even with the latch set. Otherwise it needs the latch set. When accepted it loads data bit 7 into the flag and data bits 3:2 into the block-protect field, ignores the other data bits, and pulses wrsr_grant_o. When refused it pulses wrsr_deny_o and leaves the configuration unchanged.
- R10: When the busy input falls, the latch clears on that clock.
- R11: While the registered busy bit is 1, requests and configuration writes are denied and the latch is left unchanged. The status byte stays readable and shows the busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wren_i | input | 1 | Write enable command decoded (one-cycle strobe) |
| wrdi_i | input | 1 | Write disable command decoded (one-cycle strobe) |
| wrsr_i | input | 1 | Configuration write command with data byte complete |
| wrsr_data_i | input | 8 | Data byte of the configuration write |
| frame_end_i | input | 1 | Strobe for the select line going inactive |
| frame_bits_i | input | FB_W | Bits clocked in during the frame that is ending |
| req_i | input | 1 | Write or erase request strobe |
| req_chip_i | input | 1 | Request is a whole-array erase |
| req_addr_i | input | ADDR_W | Target byte address of the request |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wip_i | input | 1 | Array write cycle in progress |
| status_o | output | 8 | Status byte |
| req_grant_o | output | 1 | Request may proceed |
| req_deny_o | output | 1 | Request refused |
| wrsr_grant_o | output | 1 | Configuration write accepted |
| wrsr_deny_o | output | 1 | Configuration write refused |

## Verification
The bench builds the block with its defaults: ADDR_W = 17, FB_W = 6 and an eight-bit enable frame. This places the quarter and half boundaries at 18000h and 10000h, so the bench can probe the addresses on each side of each boundary. With a six-bit frame counter the bench can present a frame end at 9 bits next to one at exactly 8, which exercises the exact-count rule of the enable.

// File: rtl/wep_pkg.sv
// Shared types and helpers for the write enable / block protection unit.
// Assumes an eight-bit status byte with a fixed field layout.
package wep_pkg;

    // Protection configuration written by a configuration write.
    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } prot_cfg_t;

    localparam int STATUS_W   = 8;
    localparam int ST_WIP_BIT = 0;
    localparam int ST_WEL_BIT = 1;
    localparam int ST_BP_LO   = 2;
    localparam int ST_WPEN    = 7;

    localparam logic [1:0] BP_NONE    = 2'b00;
    localparam logic [1:0] BP_QUARTER = 2'b01;
    localparam logic [1:0] BP_HALF    = 2'b10;
    localparam logic [1:0] BP_ALL     = 2'b11;

    // Assemble the status byte; unused bits read zero.
    function automatic logic [STATUS_W-1:0] pack_status(prot_cfg_t c, logic wel, logic wip);
        logic [STATUS_W-1:0] s;
        s                     = '0;
        s[ST_WPEN]            = c.wpen;
        s[ST_BP_LO+1:ST_BP_LO] = c.bp;
        s[ST_WEL_BIT]         = wel;
        s[ST_WIP_BIT]         = wip;
        return s;
    endfunction

    // Extract the writable fields from a configuration data byte.
    function automatic prot_cfg_t unpack_cfg(logic [STATUS_W-1:0] d);
        prot_cfg_t c;
        c.wpen = d[ST_WPEN];
        c.bp   = d[ST_BP_LO+1:ST_BP_LO];
        return c;
    endfunction

endpackage

// File: rtl/wep_enable_latch.sv
// Write enable latch with deferred set.
// An enable strobe is held as pending and becomes the latch only when the
// frame closes with exactly CMD_BITS bits. Clear requests win over a set.
// Assumes strobes are one cycle wide and synchronous to clk.
module wep_enable_latch #(
    parameter int FB_W     = 6,
    parameter int CMD_BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wren_i,
    input  logic            wrdi_i,
    input  logic            frame_end_i,
    input  logic [FB_W-1:0] frame_bits_i,
    input  logic            clear_i,
    output logic            wel_o
);

    localparam logic [FB_W-1:0] CMD_LEN = FB_W'(CMD_BITS);

    logic pend_q;
    logic wel_q;
    logic commit;

    // Frame closed cleanly after an enable command.
    assign commit = frame_end_i && pend_q && (frame_bits_i == CMD_LEN);

    // Track an enable waiting for its frame to close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wrdi_i || frame_end_i) begin
            pend_q <= 1'b0;
        end else if (wren_i) begin
            pend_q <= 1'b1;
        end
    end

    // Latch itself: clears take priority over the deferred set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (wrdi_i || clear_i) begin
            wel_q <= 1'b0;
        end else if (commit) begin
            wel_q <= 1'b1;
        end
    end

    assign wel_o = wel_q;

    // R2: the latch only rises at a frame end.
    p_set_at_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(frame_end_i));

    // R4: a disable strobe leaves the latch clear.
    p_wrdi_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi_i |=> !wel_q);

endmodule

// File: rtl/wep_region_cmp.sv
// Protected-range compare. The protected region grows downward from the top
// of the array in quarters selected by the block-protect field.
// Assumes ADDR_W >= 2 so that quarter boundaries exist.
module wep_region_cmp #(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bp_i,
    input  logic              chip_i,
    output logic              hit_o
);

    import wep_pkg::*;

    localparam int TOP = ADDR_W - 1;

    logic in_upper_half;
    logic in_upper_quarter;

    assign in_upper_half    = addr_i[TOP];
    assign in_upper_quarter = addr_i[TOP] && addr_i[TOP-1];

    // Decide whether the target touches the protected region.
    always_comb begin
        if (chip_i) begin
            hit_o = (bp_i != BP_NONE);
        end else begin
            unique case (bp_i)
                BP_NONE:    hit_o = 1'b0;
                BP_QUARTER: hit_o = in_upper_quarter;
                BP_HALF:    hit_o = in_upper_half;
                default:    hit_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/wep_cfg_reg.sv
// Protection configuration register with write gating.
// A configuration write is refused while the array is busy, when the
// protection-enable flag is set and the protect pin is low, or when the
// write enable latch is clear. Decisions are registered pulses.
module wep_cfg_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrsr_i,
    input  logic [7:0]        data_i,
    input  logic              wel_i,
    input  logic              busy_i,
    input  logic              wp_n_i,
    output wep_pkg::prot_cfg_t cfg_o,
    output logic              grant_o,
    output logic              deny_o
);

    import wep_pkg::*;

    prot_cfg_t cfg_q;
    logic      grant_q;
    logic      deny_q;
    logic      locked;
    logic      accept;

    assign locked = cfg_q.wpen && !wp_n_i;
    assign accept = wrsr_i && !busy_i && !locked && wel_i;

    // Load the configuration when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= unpack_cfg(data_i);
        end
    end

    // Register the grant and deny pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= accept;
            deny_q  <= wrsr_i && !accept;
        end
    end

    assign cfg_o   = cfg_q;
    assign grant_o = grant_q;
    assign deny_o  = deny_q;

    // R9: pin lock refuses the write and holds the configuration.
    p_pin_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_i && cfg_q.wpen && !wp_n_i) |=> (deny_q && $stable(cfg_q)));

    // R9: configuration only changes after a grant.
    p_cfg_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q) |-> grant_q);

endmodule

// File: rtl/wep_guard.sv
// Top of the write enable and block protection unit.
// Combines the enable latch, the protected-range compare and the
// configuration register; registers the busy input and decides on
// write/erase requests one clock after they are presented.
// Assumes all inputs are synchronous to clk.
module wep_guard #(
    parameter int ADDR_W   = 17,
    parameter int FB_W     = 6,
    parameter int CMD_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              frame_end_i,
    input  logic [FB_W-1:0]   frame_bits_i,
    input  logic              req_i,
    input  logic              req_chip_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              wp_n_i,
    input  logic              wip_i,
    output logic [7:0]        status_o,
    output logic              req_grant_o,
    output logic              req_deny_o,
    output logic              wrsr_grant_o,
    output logic              wrsr_deny_o
);

    import wep_pkg::*;

    logic      wip_q;
    logic      wip_fall;
    logic      wel;
    logic      hit;
    logic      req_ok;
    logic      prot_clear;
    logic      grant_q;
    logic      deny_q;
    prot_cfg_t cfg;

    assign wip_fall   = wip_q && !wip_i;
    assign req_ok     = req_i && !wip_q && wel && !hit;
    assign prot_clear = req_i && !wip_q && hit;

    // Register the busy level for status and gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wip_q <= 1'b0;
        end else begin
            wip_q <= wip_i;
        end
    end

    wep_enable_latch #(
        .FB_W     (FB_W),
        .CMD_BITS (CMD_BITS)
    ) latch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wren_i       (wren_i),
        .wrdi_i       (wrdi_i),
        .frame_end_i  (frame_end_i),
        .frame_bits_i (frame_bits_i),
        .clear_i      (prot_clear || wip_fall),
        .wel_o        (wel)
    );

    wep_region_cmp #(
        .ADDR_W (ADDR_W)
    ) cmp_i (
        .addr_i (req_addr_i),
        .bp_i   (cfg.bp),
        .chip_i (req_chip_i),
        .hit_o  (hit)
    );

    wep_cfg_reg cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrsr_i  (wrsr_i),
        .data_i  (wrsr_data_i),
        .wel_i   (wel),
        .busy_i  (wip_q),
        .wp_n_i  (wp_n_i),
        .cfg_o   (cfg),
        .grant_o (wrsr_grant_o),
        .deny_o  (wrsr_deny_o)
    );

    // Register the request decision as grant or deny pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= req_ok;
            deny_q  <= req_i && !req_ok;
        end
    end

    assign req_grant_o = grant_q;
    assign req_deny_o  = deny_q;
    assign status_o    = pack_status(cfg, wel, wip_q);

    // R7: grant and deny are exclusive.
    p_grant_deny_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant_o && req_deny_o));

    // R7: a grant needs the latch set in the request cycle.
    p_grant_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant_o |-> $past(status_o[ST_WEL_BIT]));

    // R8: a protected target clears the latch.
    p_prot_clears_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !wip_q && hit) |=> (req_deny_o && !status_o[ST_WEL_BIT]));

    // R10: end of a write cycle clears the latch.
    p_wip_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_q && !wip_i) |=> !status_o[ST_WEL_BIT]);

    // R11: requests while busy are denied.
    p_busy_deny_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && wip_q) |=> req_deny_o);

    // R5: unused status bits stay zero.
    p_status_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

endmodule

// File: tb/wep_guard_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: each drive step queues the expected outputs for the
// following clock; a monitor pops and compares them on the falling edge.
module wep_guard_tb_top;

    localparam int ADDR_W = 17;
    localparam int FB_W   = 6;

    typedef struct {
        int         due;
        logic [7:0] st;
        logic       rg;
        logic       rd;
        logic       sg;
        logic       sd;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
    logic [7:0]        wdata = 8'h00;
    logic              fend = 1'b0;
    logic [FB_W-1:0]   fbits = '0;
    logic              req = 1'b0, chip = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wp_n = 1'b1, wip = 1'b0;
    logic [7:0]        status;
    logic              rg, rd, sg, sd;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wep_guard #(.ADDR_W(ADDR_W), .FB_W(FB_W), .CMD_BITS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
        .wrsr_data_i(wdata), .frame_end_i(fend), .frame_bits_i(fbits),
        .req_i(req), .req_chip_i(chip), .req_addr_i(addr), .wp_n_i(wp_n),
        .wip_i(wip), .status_o(status), .req_grant_o(rg), .req_deny_o(rd),
        .wrsr_grant_o(sg), .wrsr_deny_o(sd)
    );

    // Queue expectations for the next edge, let it pass, drop strobes.
    task automatic tick(input logic [7:0] st, input logic erg, input logic erd,
                        input logic esg, input logic esd, input string tag);
        exp_t e;
        e.due = cyc + 1; e.st = st; e.rg = erg; e.rd = erd;
        e.sg = esg; e.sd = esd; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #2;
        wren = 1'b0; wrdi = 1'b0; wrsr = 1'b0; fend = 1'b0;
        req = 1'b0; chip = 1'b0;
    endtask

    task automatic set_wel(input logic [7:0] st_before, input string tag);
        wren = 1'b1;
        tick(st_before, 0, 0, 0, 0, tag);
        fend = 1'b1; fbits = 6'd8;
        tick(st_before | 8'h02, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare outputs against the front of the queue.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (status !== e.st || rg !== e.rg || rd !== e.rd ||
                sg !== e.sg || sd !== e.sd) begin
                errors++;
                $display("FAIL %s: got st=%02h rg=%b rd=%b sg=%b sd=%b exp st=%02h rg=%b rd=%b sg=%b sd=%b",
                         e.tag, status, rg, rd, sg, sd, e.st, e.rg, e.rd, e.sg, e.sd);
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got hang exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (status !== 8'h00 || rg || rd || sg || sd) begin
            errors++;
            $display("FAIL R1: got st=%02h exp st=00 and no pulses", status);
        end
        @(posedge clk); #2;
        rst_n = 1'b1;
        tick(8'h00, 0, 0, 0, 0, "R1 after reset");

        // R2: clean eight-bit frame sets the latch
        wren = 1'b1; tick(8'h00, 0, 0, 0, 0, "R2 pending not visible");
        fend = 1'b1; fbits = 6'd8; tick(8'h02, 0, 0, 0, 0, "R2 set at frame end");
        // R4: disable
        wrdi = 1'b1; tick(8'h00, 0, 0, 0, 0, "R4 wrdi clears");
        // R2: wrong bit count drops the enable
        wren = 1'b1; tick(8'h00, 0, 0, 0, 0, "R2 pending");
        fend = 1'b1; fbits = 6'd9; tick(8'h00, 0, 0, 0, 0, "R2 nine bits ignored");
        fend = 1'b1; fbits = 6'd8; tick(8'h00, 0, 0, 0, 0, "R2 nothing pending");
        // R3: write in the same frame as the enable
        wren = 1'b1; tick(8'h00, 0, 0, 0, 0, "R3 pending");
        req = 1'b1; addr = 17'h00000; tick(8'h00, 0, 1, 0, 0, "R3 same-frame write denied");
        fend = 1'b1; fbits = 6'd8; tick(8'h02, 0, 0, 0, 0, "R3 R8 enable kept");
        // R4: disable cancels a pending enable
        wrdi = 1'b1; tick(8'h00, 0, 0, 0, 0, "R4 clear");
        wren = 1'b1; tick(8'h00, 0, 0, 0, 0, "R4 pending");
        wrdi = 1'b1; tick(8'h00, 0, 0, 0, 0, "R4 cancel");
        fend = 1'b1; fbits = 6'd8; tick(8'h00, 0, 0, 0, 0, "R4 pending cancelled");
        // R7 grant, R11 busy, R10 end of cycle
        set_wel(8'h00, "R7 setup");
        req = 1'b1; addr = 17'h1FFFF; tick(8'h02, 1, 0, 0, 0, "R7 grant unprotected");
        wip = 1'b1; tick(8'h03, 0, 0, 0, 0, "R5 R11 busy visible");
        req = 1'b1; addr = 17'h00000; tick(8'h03, 0, 1, 0, 0, "R11 busy deny keeps WEL");
        wip = 1'b0; tick(8'h00, 0, 0, 0, 0, "R10 WEL clears at end");
        // R9 without the latch
        wrsr = 1'b1; wdata = 8'hFF; tick(8'h00, 0, 0, 0, 1, "R9 no WEL refused");
        set_wel(8'h00, "R9 setup");
        wrsr = 1'b1; wdata = 8'hFF; tick(8'h8E, 0, 0, 1, 0, "R9 R5 accepted, 6:4 ignored");
        wp_n = 1'b0;
        wrsr = 1'b1; wdata = 8'h00; tick(8'h8E, 0, 0, 0, 1, "R9 pin lock");
        wp_n = 1'b1;
        wrsr = 1'b1; wdata = 8'h84; tick(8'h86, 0, 0, 1, 0, "R9 quarter protect");
        // R6 quarter
        req = 1'b1; addr = 17'h17FFF; tick(8'h86, 1, 0, 0, 0, "R6 below quarter");
        req = 1'b1; addr = 17'h18000; tick(8'h84, 0, 1, 0, 0, "R6 R8 quarter hit clears WEL");
        set_wel(8'h84, "R6 setup");
        req = 1'b1; chip = 1'b1; tick(8'h84, 0, 1, 0, 0, "R6 chip erase refused");
        // R6 half
        set_wel(8'h84, "R6 setup");
        wrsr = 1'b1; wdata = 8'h08; tick(8'h0A, 0, 0, 1, 0, "R9 half protect");
        req = 1'b1; addr = 17'h0FFFF; tick(8'h0A, 1, 0, 0, 0, "R6 below half");
        req = 1'b1; addr = 17'h10000; tick(8'h08, 0, 1, 0, 0, "R6 half hit");
        // R6 all
        set_wel(8'h08, "R6 setup");
        wrsr = 1'b1; wdata = 8'h0C; tick(8'h0E, 0, 0, 1, 0, "R9 full protect");
        req = 1'b1; addr = 17'h00000; tick(8'h0C, 0, 1, 0, 0, "R6 all protected");
        // R6 none with chip erase
        set_wel(8'h0C, "R6 setup");
        wrsr = 1'b1; wdata = 8'h00; tick(8'h02, 0, 0, 1, 0, "R9 no protect");
        req = 1'b1; chip = 1'b1; tick(8'h02, 1, 0, 0, 0, "R6 chip erase allowed");
        // R11 configuration write while busy
        wip = 1'b1; tick(8'h03, 0, 0, 0, 0, "R11 busy");
        wrsr = 1'b1; wdata = 8'h80; tick(8'h03, 0, 0, 0, 1, "R11 wrsr busy denied");
        wip = 1'b0; tick(8'h00, 0, 0, 0, 0, "R10 clear");

        @(posedge clk); @(negedge clk); #1;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d left exp 0", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule